// File: doc/BRIEF.md
# In-band XON/XOFF flow control engine

This block adds character-based flow control to one serial channel. It watches every character coming out of the receive deserializer and compares it with four programmable codes: two "resume" (XON) codes and two "pause" (XOFF) codes. A matching pause code asserts a hold toward the local transmitter. A matching resume code releases that hold. Matched codes are consumed here and never reach the receive FIFO. Every other character is forwarded one cycle later.

In the other direction, the block watches two flags from the local receive FIFO: a fill-trigger flag and a drain-release flag. It asks the transmitter to send a pause code when the FIFO fills, and a resume code once the FIFO has drained. The request is a level with its character. It stays up until the transmitter acknowledges taking the character, which the transmitter does only after its shift register has finished the character already in flight. Injected codes go ahead of queued data and are sent even while the hold is asserted.

A small register port holds the codes, the mode and a status word. Reading the status word clears the pause-detected interrupt.

Top module: `swfc_engine`

## Requirements
- R1: Addresses 0, 1, 2 and 3 hold XON1, XON2, XOFF1 and XOFF2. They are written with `cfg_we`. A read with `cfg_re` returns the value on `cfg_rdata` one cycle later.
- R2: The mode word at address 4 has these fields: bits[1:0] select matching (0 off, 1 single pair 1, 2 single pair 2, 3 two-character sequence), bit2 enables auto insertion, bit3 is the enhanced enable, and bit4 is the interrupt enable. With matching off, every received character is forwarded unchanged one cycle later, and `tx_hold` is forced low.
- R3: In mode 1, a character equal to XOFF1 sets `tx_hold`, and a character equal to XON1 clears it. Neither is forwarded. XOFF wins when both codes are equal. Pair-2 codes are forwarded as data.
- R4: Mode 2 behaves like mode 1 but uses XON2 and XOFF2, and forwards pair-1 codes as data.
- R5: In mode 3, XOFF1 followed by XOFF2 sets `tx_hold`, and XON1 followed by XON2 clears it. Both characters of a completed pair are dropped.
- R6: In mode 3, if a held first character is not followed by its partner, the first character is forwarded. The second character is then evaluated afresh in the next cycle, and it may itself start a new pair.
- R7: A detected pause sets a flag, which is status bit0 at address 5 (bit1 shows `tx_hold`, bit2 shows that a pause was sent). `irq` is the flag gated by the interrupt enable. Reading address 5 returns the flag and clears it. A new detection in the same cycle wins.
- R8: The interrupt enable bit changes only on a write made while the enhanced enable is already 1.
- R9: With auto insertion on, `fifo_trig` while no pause is outstanding raises `ins_req` with the pause code. The request and its character stay stable until `ins_ack`, and only one pause is sent per crossing.
- R10: Once a pause has been sent, `fifo_rel` requests one resume. Modes 0, 1 and 3 send the pair-1 code first, and mode 2 sends the pair-2 code. Mode 3 follows the first code with its pair-2 partner, as a second request.
- R11: Insertion requests are raised whatever the state of `tx_hold`.
- R12: After reset, `tx_hold`, `ins_req`, `irq`, `rx_pass_valid` and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CW | Received character |
| rx_pass_valid | output | 1 | Character forwarded to the receive FIFO |
| rx_pass_data | output | CW | Forwarded character |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | CW | Register write data |
| cfg_rdata | output | CW | Register read data, one cycle after `cfg_re` |
| fifo_trig | input | 1 | Receive FIFO at or above its trigger level |
| fifo_rel | input | 1 | Receive FIFO below its release level |
| tx_hold | output | 1 | Halt normal transmit data |
| ins_req | output | 1 | Request to inject a flow-control character |
| ins_data | output | CW | Character to inject |
| ins_ack | input | 1 | Transmitter has taken the injected character |
| irq | output | 1 | Pause-detected interrupt |

## Verification
The checker assumes that `rx_valid` is never high in two consecutive cycles. This holds naturally for a serial receiver, and the replay of a broken sequence uses the idle cycle that follows. It also assumes that `ins_ack` is pulsed only while `ins_req` is high, and that `fifo_trig` and `fifo_rel` are never high together. The bench spaces received characters at least four cycles apart, pulses the acknowledge for one cycle only while a request is visible, and drops one FIFO flag before raising the other.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic [1:0] {
    MM_OFF   = 2'd0,
    MM_PAIR1 = 2'd1,
    MM_PAIR2 = 2'd2,
    MM_SEQ   = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    IS_IDLE   = 2'd0,
    IS_FIRST  = 2'd1,
    IS_SECOND = 2'd2
  } ins_state_e;

  localparam int REG_XON1  = 0;
  localparam int REG_XON2  = 1;
  localparam int REG_XOFF1 = 2;
  localparam int REG_XOFF2 = 3;
  localparam int REG_MODE  = 4;
  localparam int REG_STAT  = 5;
  localparam int NUM_CODES = 4;
endpackage

// File: rtl/swfc_regs.sv
module swfc_regs
  import swfc_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  input  logic          st_flag,
  input  logic          st_hold,
  input  logic          st_stopped,
  output logic [CW-1:0] on_a,
  output logic [CW-1:0] on_b,
  output logic [CW-1:0] off_a,
  output logic [CW-1:0] off_b,
  output match_mode_e   match_mode,
  output logic          auto_en,
  output logic          irq_en,
  output logic          stat_rd,
  output logic [CW-1:0] rdata
);
  localparam int PADM = CW - 5;
  localparam int PADS = CW - 3;

  logic [CW-1:0] code_q [NUM_CODES];
  logic          enh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CODES; i++) code_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_CODES; i++)
        if (addr == AW'(i)) code_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_mode <= MM_OFF;
      auto_en    <= 1'b0;
      enh_q      <= 1'b0;
      irq_en     <= 1'b0;
    end else if (we && addr == AW'(REG_MODE)) begin
      match_mode <= match_mode_e'(wdata[1:0]);
      auto_en    <= wdata[2];
      enh_q      <= wdata[3];
      if (enh_q) irq_en <= wdata[4];
    end
  end

  assign on_a    = code_q[REG_XON1];
  assign on_b    = code_q[REG_XON2];
  assign off_a   = code_q[REG_XOFF1];
  assign off_b   = code_q[REG_XOFF2];
  assign stat_rd = re && (addr == AW'(REG_STAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      if (addr < AW'(NUM_CODES))
        rdata <= code_q[addr[1:0]];
      else if (addr == AW'(REG_MODE))
        rdata <= {{PADM{1'b0}}, irq_en, enh_q, auto_en, match_mode};
      else if (addr == AW'(REG_STAT))
        rdata <= {{PADS{1'b0}}, st_stopped, st_hold, st_flag};
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/swfc_match.sv
module swfc_match
  import swfc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  match_mode_e   match_mode,
  input  logic [CW-1:0] on_a,
  input  logic [CW-1:0] on_b,
  input  logic [CW-1:0] off_a,
  input  logic [CW-1:0] off_b,
  input  logic          in_valid,
  input  logic [CW-1:0] in_data,
  output logic          pass_valid,
  output logic [CW-1:0] pass_data,
  output logic          halt_p,
  output logic          resume_p
);
  logic          pend_v, pend_v_n, pend_off, pend_off_n;
  logic [CW-1:0] pend_d, pend_d_n;
  logic          rep_v, rep_v_n;
  logic [CW-1:0] rep_d, rep_d_n;
  logic          pass_v_n, halt_n, resume_n;
  logic [CW-1:0] pass_d_n;
  logic          cur_v;
  logic [CW-1:0] cur_d, sel_on, sel_off;

  always_comb begin
    cur_v      = rep_v | in_valid;
    cur_d      = rep_v ? rep_d : in_data;
    sel_on     = (match_mode == MM_PAIR2) ? on_b : on_a;
    sel_off    = (match_mode == MM_PAIR2) ? off_b : off_a;
    pend_v_n   = pend_v;
    pend_off_n = pend_off;
    pend_d_n   = pend_d;
    rep_v_n    = 1'b0;
    rep_d_n    = rep_d;
    pass_v_n   = 1'b0;
    pass_d_n   = pass_data;
    halt_n     = 1'b0;
    resume_n   = 1'b0;
    case (match_mode)
      MM_OFF: begin
        pend_v_n = 1'b0;
        if (cur_v) begin
          pass_v_n = 1'b1;
          pass_d_n = cur_d;
        end
      end
      MM_PAIR1, MM_PAIR2: begin
        pend_v_n = 1'b0;
        if (cur_v) begin
          if (cur_d == sel_off)     halt_n = 1'b1;
          else if (cur_d == sel_on) resume_n = 1'b1;
          else begin
            pass_v_n = 1'b1;
            pass_d_n = cur_d;
          end
        end
      end
      default: begin
        if (cur_v) begin
          if (pend_v) begin
            pend_v_n = 1'b0;
            if (pend_off && cur_d == off_b)       halt_n = 1'b1;
            else if (!pend_off && cur_d == on_b)  resume_n = 1'b1;
            else begin
              pass_v_n = 1'b1;
              pass_d_n = pend_d;
              rep_v_n  = 1'b1;
              rep_d_n  = cur_d;
            end
          end else if (cur_d == off_a) begin
            pend_v_n   = 1'b1;
            pend_off_n = 1'b1;
            pend_d_n   = cur_d;
          end else if (cur_d == on_a) begin
            pend_v_n   = 1'b1;
            pend_off_n = 1'b0;
            pend_d_n   = cur_d;
          end else begin
            pass_v_n = 1'b1;
            pass_d_n = cur_d;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_off   <= 1'b0;
      pend_d     <= '0;
      rep_v      <= 1'b0;
      rep_d      <= '0;
      pass_valid <= 1'b0;
      pass_data  <= '0;
      halt_p     <= 1'b0;
      resume_p   <= 1'b0;
    end else begin
      pend_v     <= pend_v_n;
      pend_off   <= pend_off_n;
      pend_d     <= pend_d_n;
      rep_v      <= rep_v_n;
      rep_d      <= rep_d_n;
      pass_valid <= pass_v_n;
      pass_data  <= pass_d_n;
      halt_p     <= halt_n;
      resume_p   <= resume_n;
    end
  end
endmodule

// File: rtl/swfc_insert.sv
module swfc_insert
  import swfc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_en,
  input  match_mode_e   match_mode,
  input  logic          fifo_trig,
  input  logic          fifo_rel,
  input  logic [CW-1:0] on_a,
  input  logic [CW-1:0] on_b,
  input  logic [CW-1:0] off_a,
  input  logic [CW-1:0] off_b,
  input  logic          ins_ack,
  output logic          ins_req,
  output logic [CW-1:0] ins_data,
  output logic          stopped
);
  ins_state_e state;
  logic       kind_off;
  logic       use_b, two_char;

  assign use_b    = (match_mode == MM_PAIR2);
  assign two_char = (match_mode == MM_SEQ);
  assign ins_req  = (state != IS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= IS_IDLE;
      kind_off <= 1'b0;
      stopped  <= 1'b0;
      ins_data <= '0;
    end else if (!auto_en) begin
      state   <= IS_IDLE;
      stopped <= 1'b0;
    end else begin
      case (state)
        IS_IDLE: begin
          if (!stopped && fifo_trig) begin
            stopped  <= 1'b1;
            kind_off <= 1'b1;
            ins_data <= use_b ? off_b : off_a;
            state    <= IS_FIRST;
          end else if (stopped && fifo_rel) begin
            stopped  <= 1'b0;
            kind_off <= 1'b0;
            ins_data <= use_b ? on_b : on_a;
            state    <= IS_FIRST;
          end
        end
        IS_FIRST: begin
          if (ins_ack) begin
            if (two_char) begin
              ins_data <= kind_off ? off_b : on_b;
              state    <= IS_SECOND;
            end else begin
              state <= IS_IDLE;
            end
          end
        end
        default: begin
          if (ins_ack) state <= IS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic          rx_pass_valid,
  output logic [CW-1:0] rx_pass_data,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata,
  input  logic          fifo_trig,
  input  logic          fifo_rel,
  output logic          tx_hold,
  output logic          ins_req,
  output logic [CW-1:0] ins_data,
  input  logic          ins_ack,
  output logic          irq
);
  logic [CW-1:0] on_a, on_b, off_a, off_b;
  match_mode_e   match_mode;
  logic          auto_en, irq_en, stat_rd, stopped;
  logic          halt_p, resume_p, mode_off;
  logic          xoff_flag_q, xoff_flag_d;

  swfc_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .re(cfg_re), .addr(cfg_addr),
    .wdata(cfg_wdata), .st_flag(xoff_flag_q), .st_hold(tx_hold),
    .st_stopped(stopped), .on_a(on_a), .on_b(on_b), .off_a(off_a),
    .off_b(off_b), .match_mode(match_mode), .auto_en(auto_en),
    .irq_en(irq_en), .stat_rd(stat_rd), .rdata(cfg_rdata)
  );

  swfc_match #(.CW(CW)) u_match (
    .clk(clk), .rst(rst), .match_mode(match_mode), .on_a(on_a),
    .on_b(on_b), .off_a(off_a), .off_b(off_b), .in_valid(rx_valid),
    .in_data(rx_data), .pass_valid(rx_pass_valid),
    .pass_data(rx_pass_data), .halt_p(halt_p), .resume_p(resume_p)
  );

  swfc_insert #(.CW(CW)) u_insert (
    .clk(clk), .rst(rst), .auto_en(auto_en), .match_mode(match_mode),
    .fifo_trig(fifo_trig), .fifo_rel(fifo_rel), .on_a(on_a), .on_b(on_b),
    .off_a(off_a), .off_b(off_b), .ins_ack(ins_ack), .ins_req(ins_req),
    .ins_data(ins_data), .stopped(stopped)
  );

  assign mode_off    = (match_mode == MM_OFF);
  assign xoff_flag_d = halt_p | (xoff_flag_q & ~stat_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold     <= 1'b0;
      xoff_flag_q <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (mode_off)      tx_hold <= 1'b0;
      else if (halt_p)   tx_hold <= 1'b1;
      else if (resume_p) tx_hold <= 1'b0;
      xoff_flag_q <= xoff_flag_d;
      irq         <= xoff_flag_d & irq_en;
    end
  end
endmodule

// File: rtl/swfc_engine_chk.sv
module swfc_engine_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_pass_valid,
  input logic          mode_off,
  input logic          tx_hold,
  input logic          halt_p,
  input logic          resume_p,
  input logic          xoff_flag_q,
  input logic          irq,
  input logic          irq_en,
  input logic          auto_en,
  input logic          ins_req,
  input logic          ins_ack,
  input logic [CW-1:0] ins_data
);
  // R2: with matching off, every character is forwarded
  assert_off_forward_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && mode_off) |=> rx_pass_valid);

  // R3: the hold rises only after a detected pause
  assert_hold_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_hold) |-> $past(halt_p));

  // R3: pause and resume are never detected together
  assert_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(halt_p && resume_p));

  // R7: a detection sets the flag
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    halt_p |=> xoff_flag_q);

  // R7: the flag only rises after a detection
  assert_flag_src_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(xoff_flag_q) |-> $past(halt_p));

  // R7: the interrupt needs its enable
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R9: a pending request and its character stay until acknowledged
  assert_req_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (ins_req && !ins_ack && auto_en) |=> (ins_req && $stable(ins_data)));
endmodule

bind swfc_engine swfc_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_pass_valid(rx_pass_valid),
  .mode_off(mode_off), .tx_hold(tx_hold), .halt_p(halt_p),
  .resume_p(resume_p), .xoff_flag_q(xoff_flag_q), .irq(irq),
  .irq_en(irq_en), .auto_en(auto_en), .ins_req(ins_req),
  .ins_ack(ins_ack), .ins_data(ins_data)
);

// File: tb/swfc_engine_tb.sv
`timescale 1ns/1ps
module swfc_engine_tb;
  localparam int CW = 8;
  localparam int AW = 3;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h91, OFF1 = 8'h13, OFF2 = 8'h93;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [CW-1:0] rx_data = '0;
  logic          rx_pass_valid;
  logic [CW-1:0] rx_pass_data;
  logic          cfg_we = 1'b0, cfg_re = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_rdata;
  logic          fifo_trig = 1'b0, fifo_rel = 1'b0;
  logic          tx_hold, ins_req, ins_ack = 1'b0, irq;
  logic [CW-1:0] ins_data;

  int checks = 0;
  int failures = 0;
  logic [7:0] pass_log [64];
  int pass_cnt = 0;

  always #2.5 clk = ~clk;

  swfc_engine #(.CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_pass_valid(rx_pass_valid), .rx_pass_data(rx_pass_data),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_trig(fifo_trig),
    .fifo_rel(fifo_rel), .tx_hold(tx_hold), .ins_req(ins_req),
    .ins_data(ins_data), .ins_ack(ins_ack), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst && rx_pass_valid) begin
      pass_log[pass_cnt % 64] = rx_pass_data;
      pass_cnt = pass_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = CW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = AW'(a);
    @(negedge clk);
    cfg_re = 1'b0;
    d = int'(cfg_rdata);
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = c;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    ins_ack = 1'b1;
    @(negedge clk);
    ins_ack = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    chk("R12 tx_hold", int'(tx_hold), 0);
    chk("R12 ins_req", int'(ins_req), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 rx_pass_valid", int'(rx_pass_valid), 0);
    rd(2, v); chk("R12 code reg", v, 0);
    rd(4, v); chk("R12 mode reg", v, 0);
  endtask

  task automatic t_regs();
    int v;
    wr(0, ON1); wr(1, ON2); wr(2, OFF1); wr(3, OFF2);
    rd(0, v); chk("R1 xon1", v, ON1);
    rd(1, v); chk("R1 xon2", v, ON2);
    rd(2, v); chk("R1 xoff1", v, OFF1);
    rd(3, v); chk("R1 xoff2", v, OFF2);
  endtask

  task automatic t_passthru();
    int b;
    wr(4, 0);
    b = pass_cnt;
    send(OFF1);
    chk("R2 forwarded count", pass_cnt - b, 1);
    chk("R2 forwarded data", int'(pass_log[b % 64]), OFF1);
    chk("R2 no hold", int'(tx_hold), 0);
  endtask

  task automatic t_single1();
    int b;
    wr(4, 1);
    b = pass_cnt;
    send(8'h41);
    chk("R3 data forwarded", int'(pass_log[b % 64]), 8'h41);
    send(OFF1);
    chk("R3 xoff1 halts", int'(tx_hold), 1);
    send(OFF2);
    chk("R3 pair2 code forwarded", int'(pass_log[(b + 1) % 64]), OFF2);
    send(ON1);
    chk("R3 xon1 resumes", int'(tx_hold), 0);
    chk("R3 matched codes dropped", pass_cnt - b, 2);
  endtask

  task automatic t_single2();
    int b;
    wr(4, 2);
    b = pass_cnt;
    send(OFF2);
    chk("R4 xoff2 halts", int'(tx_hold), 1);
    send(OFF1);
    chk("R4 pair1 code forwarded", int'(pass_log[b % 64]), OFF1);
    send(ON2);
    chk("R4 xon2 resumes", int'(tx_hold), 0);
    chk("R4 count", pass_cnt - b, 1);
  endtask

  task automatic t_seq();
    int b;
    wr(4, 3);
    b = pass_cnt;
    send(OFF1);
    chk("R5 first alone no halt", int'(tx_hold), 0);
    send(OFF2);
    chk("R5 pair halts", int'(tx_hold), 1);
    send(ON1); send(ON2);
    chk("R5 pair resumes", int'(tx_hold), 0);
    chk("R5 pairs dropped", pass_cnt - b, 0);
  endtask

  task automatic t_partial();
    int b;
    wr(4, 3);
    b = pass_cnt;
    send(OFF1); send(8'h41);
    chk("R6 broken count", pass_cnt - b, 2);
    chk("R6 first order", int'(pass_log[b % 64]), OFF1);
    chk("R6 second order", int'(pass_log[(b + 1) % 64]), 8'h41);
    chk("R6 no hold", int'(tx_hold), 0);
    b = pass_cnt;
    send(OFF1); send(OFF1); send(OFF2);
    chk("R6 restart halts", int'(tx_hold), 1);
    chk("R6 restart count", pass_cnt - b, 1);
    chk("R6 restart data", int'(pass_log[b % 64]), OFF1);
    send(ON1); send(ON2);
    chk("R6 resume", int'(tx_hold), 0);
  endtask

  task automatic t_irq();
    int v;
    wr(4, 8'h11);
    rd(4, v); chk("R8 enable blocked", v & 8'h10, 0);
    wr(4, 8'h09);
    wr(4, 8'h19);
    rd(4, v); chk("R8 enable written", v, 8'h19);
    send(OFF1);
    chk("R7 irq raised", int'(irq), 1);
    rd(5, v); chk("R7 status flag and hold", v & 3, 3);
    chk("R7 irq cleared by read", int'(irq), 0);
    rd(5, v); chk("R7 flag cleared", v & 1, 0);
    send(ON1);
    chk("R7 resumed", int'(tx_hold), 0);
  endtask

  task automatic t_ins_single();
    wr(4, 0); wr(4, 8'h05);
    @(negedge clk); fifo_trig = 1'b1;
    @(negedge clk);
    chk("R9 xoff request", int'(ins_req), 1);
    chk("R9 xoff data", int'(ins_data), OFF1);
    repeat (3) @(negedge clk);
    chk("R9 request held", int'(ins_req), 1);
    chk("R9 data held", int'(ins_data), OFF1);
    ack();
    chk("R9 request dropped", int'(ins_req), 0);
    repeat (4) @(negedge clk);
    chk("R9 one per crossing", int'(ins_req), 0);
    fifo_trig = 1'b0; fifo_rel = 1'b1;
    @(negedge clk);
    chk("R10 xon request", int'(ins_req), 1);
    chk("R10 xon data", int'(ins_data), ON1);
    fifo_rel = 1'b0;
    ack();
    chk("R10 xon done", int'(ins_req), 0);
  endtask

  task automatic t_ins_seq();
    wr(4, 0); wr(4, 8'h07);
    @(negedge clk); fifo_trig = 1'b1;
    @(negedge clk);
    chk("R10 seq first", int'(ins_data), OFF1);
    ack();
    chk("R10 seq second req", int'(ins_req), 1);
    chk("R10 seq second data", int'(ins_data), OFF2);
    ack();
    chk("R10 seq done", int'(ins_req), 0);
    fifo_trig = 1'b0; fifo_rel = 1'b1;
    @(negedge clk);
    chk("R10 seq xon1", int'(ins_data), ON1);
    fifo_rel = 1'b0;
    ack();
    chk("R10 seq xon2", int'(ins_data), ON2);
    ack();
    chk("R10 seq xon done", int'(ins_req), 0);
  endtask

  task automatic t_ins_pair2_hold();
    wr(4, 0); wr(4, 8'h06);
    @(negedge clk); fifo_trig = 1'b1;
    @(negedge clk);
    chk("R10 pair2 xoff data", int'(ins_data), OFF2);
    fifo_trig = 1'b0;
    ack();
    wr(4, 0); wr(4, 8'h05);
    send(OFF1);
    chk("R11 held", int'(tx_hold), 1);
    @(negedge clk); fifo_trig = 1'b1;
    @(negedge clk);
    chk("R11 request while held", int'(ins_req), 1);
    fifo_trig = 1'b0;
    ack();
    send(ON1);
    chk("R11 resumed", int'(tx_hold), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_passthru();
    t_single1();
    t_single2();
    t_seq();
    t_partial();
    t_irq();
    t_ins_single();
    t_ins_seq();
    t_ins_pair2_hold();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule